// File: doc/BRIEF.md
# Serial Flash Fast-Read Responder

This block is the device side of a serial flash memory. It handles a single command, the fast read, on a four-wire SPI bus. The host lowers chip select and sends an 8-bit opcode, then a 24-bit start address, then one byte whose value is not used. From the next bit onward, the block returns bytes from its internal storage array. It begins at the requested address and moves up one byte at a time. It keeps sending for as long as chip select stays low. After the last entry of the array it continues at entry zero.

The bus pins are sampled by a system clock through synchronizer stages. The bus clock must therefore run well below the system clock. The serial output is provided as a data bit and a separate driver enable, so a pad cell can tri-state the line. The storage array is a register file with a byte-wide load port, which the surrounding logic (or a bench) uses to fill it while chip select is high.

Top module: `fastread_responder`

## Requirements
- R1: Bits are taken MSB first on rising SCK edges while chip select is low. An opcode of 0x0B starts a read, and the bytes returned equal the array contents from the start address onward.
- R2: The 24 bits after the opcode form the start address, MSB first. Only the low ADDR_BITS bits select an array entry; higher address bits have no effect.
- R3: The byte after the address is not interpreted. Any value gives the same returned data.
- R4: The first data bit is driven after the falling SCK edge that ends bit 39, so the host can sample it at the 41st rising edge. Data goes MSB first, and each bit changes only on falling SCK edges.
- R5: The output enable stays low during the opcode, address and dummy bits (the first 40 rising edges).
- R6: The address pointer advances by one after every byte, and output continues without a gap for as long as chip select stays low.
- R7: After the byte at the highest array entry (2^ADDR_BITS - 1), the next byte comes from entry 0.
- R8: For any opcode other than 0x0B, the output enable stays low for the rest of that chip-select period.
- R9: Raising chip select ends the command at any bit and drops the output enable. The next low period starts decoding again from bit 0.
- R10: SPI mode 0 (SCK idle low) and mode 3 (SCK idle high) both give the same results.
- R11: After synchronous reset, the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all bus pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial bus clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host (valid when enabled) |
| spi_miso_oe | output | 1 | Driver enable for the serial output pad |
| load_en | input | 1 | Write strobe for the storage array |
| load_addr | input | ADDR_BITS | Array entry to write |
| load_data | input | 8 | Byte written to the array |

## Verification
The bench builds the block with ADDR_BITS = 4, which gives a 16-byte array. This lets short reads cross from entry 15 back to entry 0, and lets a 20-byte stream go all the way around. Because the array is this small, a 24-bit start address with many high bits set shows that those bits are dropped. The default synchronizer depth combined with a bus clock of twelve system clocks per period places the output update well before the host samples it, in both SPI modes.

// File: rtl/fr_pkg.sv
// Package: shared constants and the command phase type for the fast-read responder.
// Assumes one command per chip-select low period.
package fr_pkg;
    localparam logic [7:0] OPC_FAST_READ = 8'h0B;
    localparam int OPC_BITS   = 8;
    localparam int ADDR_FIELD = 24;
    localparam int DUMMY_BITS = 8;
    localparam int BYTE_W     = 8;

    typedef enum logic [2:0] {
        PH_OPCODE = 3'd0,
        PH_ADDR   = 3'd1,
        PH_DUMMY  = 3'd2,
        PH_DATA   = 3'd3,
        PH_IGNORE = 3'd4
    } phase_t;
endpackage

// File: rtl/fr_pin_sync.sv
// Module: brings SCK, chip select and MOSI into the system clock domain through
// a configurable synchronizer chain and flags SCK edges. All three pins pass
// through the same depth, so their relative order is kept.
// Assumes SCK runs several times slower than clk.
module fr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_active,
    output logic mosi_s
);
    // bit order {mosi, cs_n, sck}; chip select resets to inactive
    localparam logic [2:0] IDLE_VEC = 3'b010;

    logic [2:0] chain [STAGES];
    logic       sck_prev;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: one synchronizer flop stage for the three pins.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[s] <= IDLE_VEC;
                end else if (s == 0) begin
                    chain[s] <= {mosi_in, cs_n_in, sck_in};
                end else begin
                    chain[s] <= chain[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    // Purpose: remember the last synchronized SCK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= chain[STAGES-1][0];
    end

    assign sck_rise  =  chain[STAGES-1][0] & ~sck_prev;
    assign sck_fall  = ~chain[STAGES-1][0] &  sck_prev;
    assign cs_active = ~chain[STAGES-1][1];
    assign mosi_s    =  chain[STAGES-1][2];
endmodule

// File: rtl/fr_mem_array.sv
// Module: byte-wide register array with one synchronous write port and one
// combinational read port. Depth is 2^ADDR_BITS, so addresses wrap naturally.
// Assumes writes happen only while no read command is active.
module fr_mem_array #(
    parameter int ADDR_BITS = 8,
    parameter int DATA_W    = 8
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [ADDR_BITS-1:0] wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_BITS-1:0] rd_addr,
    output logic [DATA_W-1:0]    rd_data
);
    localparam int DEPTH = 1 << ADDR_BITS;

    logic [DATA_W-1:0] store [DEPTH];

    // Purpose: write one entry when the load strobe is high.
    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    assign rd_data = store[rd_addr];
endmodule

// File: rtl/fr_cmd_ctrl.sv
// Module: command sequencer. It counts bits on rising SCK edges, decodes the
// opcode, captures the address, skips the dummy byte, and then shifts array
// bytes out on falling SCK edges. Dropping chip select clears all phase state.
// Assumes sck_rise and sck_fall are never high in the same cycle.
module fr_cmd_ctrl
    import fr_pkg::*;
#(
    parameter int ADDR_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sck_rise,
    input  logic                 sck_fall,
    input  logic                 cs_active,
    input  logic                 mosi,
    input  logic [BYTE_W-1:0]    rd_data,
    output logic [ADDR_BITS-1:0] rd_addr,
    output logic                 miso_bit,
    output logic                 miso_en
);
    localparam int CNT_W = $clog2(ADDR_FIELD);

    phase_t              phase;
    logic [CNT_W-1:0]    bit_cnt;
    logic [ADDR_FIELD-1:0] rx_sr;
    logic [ADDR_FIELD-1:0] rx_next;
    logic [ADDR_BITS-1:0] ptr;
    logic [BYTE_W-1:0]   tx_sr;
    logic [2:0]          tx_cnt;
    logic                tx_live;
    logic                byte_load;

    assign rx_next   = {rx_sr[ADDR_FIELD-2:0], mosi};
    assign byte_load = sck_fall && (phase == PH_DATA) && (tx_cnt == 3'd0);

    // Purpose: input side; advance phases on rising SCK edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            phase   <= PH_OPCODE;
            bit_cnt <= '0;
            rx_sr   <= '0;
        end else if (sck_rise) begin
            rx_sr <= rx_next;
            unique case (phase)
                PH_OPCODE: begin
                    if (bit_cnt == CNT_W'(OPC_BITS - 1)) begin
                        bit_cnt <= '0;
                        phase   <= (rx_next[BYTE_W-1:0] == OPC_FAST_READ) ? PH_ADDR : PH_IGNORE;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                PH_ADDR: begin
                    if (bit_cnt == CNT_W'(ADDR_FIELD - 1)) begin
                        bit_cnt <= '0;
                        phase   <= PH_DUMMY;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                PH_DUMMY: begin
                    if (bit_cnt == CNT_W'(DUMMY_BITS - 1)) begin
                        bit_cnt <= '0;
                        phase   <= PH_DATA;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Purpose: address pointer; capture at the last address bit, step on each byte load.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            ptr <= '0;
        end else if (sck_rise && phase == PH_ADDR && bit_cnt == CNT_W'(ADDR_FIELD - 1)) begin
            ptr <= rx_next[ADDR_BITS-1:0];
        end else if (byte_load) begin
            ptr <= ptr + 1'b1;
        end
    end

    // Purpose: output side; load or shift the transmit byte on falling SCK edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            tx_sr   <= '0;
            tx_cnt  <= '0;
            tx_live <= 1'b0;
        end else if (byte_load) begin
            tx_sr   <= rd_data;
            tx_cnt  <= 3'd7;
            tx_live <= 1'b1;
        end else if (sck_fall && phase == PH_DATA) begin
            tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
            tx_cnt <= tx_cnt - 1'b1;
        end
    end

    assign rd_addr  = ptr;
    assign miso_bit = tx_sr[BYTE_W-1];
    assign miso_en  = tx_live;

    // R5
    drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_live) |-> ($past(sck_fall) && $past(phase) == PH_DATA));

    // R8
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IGNORE) |-> !tx_live);

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_load && cs_active) |=> (ptr == $past(ptr) + 1'b1));

    // R9
    deselect_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> (phase == PH_OPCODE && !tx_live && bit_cnt == '0));

    // R4
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sck_rise && sck_fall));
endmodule

// File: rtl/fastread_responder.sv
// Module: top of the serial flash fast-read responder. It ties the pin
// synchronizer, the command sequencer and the storage array together. The
// serial output is split into data and pad enable; the enable is also gated
// directly by the raw chip select so the line releases at once.
// Assumes the system clock runs at least 6x faster than SCK.
module fastread_responder #(
    parameter int ADDR_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_sck,
    input  logic                 spi_cs_n,
    input  logic                 spi_mosi,
    output logic                 spi_miso,
    output logic                 spi_miso_oe,
    input  logic                 load_en,
    input  logic [ADDR_BITS-1:0] load_addr,
    input  logic [7:0]           load_data
);
    logic                 sck_rise;
    logic                 sck_fall;
    logic                 cs_active;
    logic                 mosi_s;
    logic [ADDR_BITS-1:0] rd_addr;
    logic [7:0]           rd_data;
    logic                 miso_en;

    fr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_in    (spi_sck),
        .cs_n_in   (spi_cs_n),
        .mosi_in   (spi_mosi),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_active (cs_active),
        .mosi_s    (mosi_s)
    );

    fr_cmd_ctrl #(.ADDR_BITS(ADDR_BITS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_active (cs_active),
        .mosi      (mosi_s),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .miso_bit  (spi_miso),
        .miso_en   (miso_en)
    );

    fr_mem_array #(.ADDR_BITS(ADDR_BITS), .DATA_W(8)) u_mem (
        .clk     (clk),
        .wr_en   (load_en),
        .wr_addr (load_addr),
        .wr_data (load_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign spi_miso_oe = miso_en & ~spi_cs_n;

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !spi_miso_oe);

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_miso_oe);
endmodule

// File: tb/test_fastread_responder.sv
// Bench: a scoreboard. The driver task acts as the SPI host, pushes expected
// bytes from a bench-side memory model, and collects received bytes; a monitor
// process pops both queues and compares them.
module test_fastread_responder;
    localparam int AB   = 4;
    localparam int NENT = 1 << AB;
    localparam int H    = 6;  // system clocks per SCK half period

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sck = 1'b0;
    logic          cs_n = 1'b1;
    logic          mosi = 1'b0;
    logic          miso;
    logic          oe;
    logic          ld_en = 1'b0;
    logic [AB-1:0] ld_addr = '0;
    logic [7:0]    ld_data = '0;

    int tests = 0;
    int fails = 0;

    logic [7:0] model [NENT];
    int    exp_q[$];
    string tag_q[$];
    int    got_q[$];

    always #4 clk = ~clk;

    fastread_responder #(.ADDR_BITS(AB), .SYNC_STAGES(2)) i_fastread_responder (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sck    (sck),
        .spi_cs_n   (cs_n),
        .spi_mosi   (mosi),
        .spi_miso   (miso),
        .spi_miso_oe(oe),
        .load_en    (ld_en),
        .load_addr  (ld_addr),
        .load_data  (ld_data)
    );

    task automatic check(input bit ok, input string what, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, expv);
        end
    endtask

    task automatic wait_h();
        repeat (H) @(negedge clk);
    endtask

    task automatic spi_bit(input int mode, input logic b, output logic rb, output logic ro);
        if (mode == 3) sck = 1'b0;
        mosi = b;
        wait_h();
        rb  = miso;
        ro  = oe;
        sck = 1'b1;
        wait_h();
        if (mode == 0) sck = 1'b0;
    endtask

    // Driver: one chip-select period. stop_bit < 40 aborts during the header.
    task automatic spi_cmd(input int mode, input logic [7:0] op, input logic [23:0] addr,
                           input logic [7:0] dmy, input int nbytes, input int stop_bit,
                           input string tag);
        logic [39:0] hdr;
        logic        rb, ro;
        logic [7:0]  by;
        bit          hdr_oe, data_gap, rej_oe;
        hdr = {op, addr, dmy};
        hdr_oe = 0; data_gap = 0; rej_oe = 0;
        sck = (mode == 3);
        wait_h(); wait_h();
        cs_n = 1'b0;
        wait_h();
        for (int i = 0; i < 40; i++) begin
            if (i < stop_bit) begin
                spi_bit(mode, hdr[39-i], rb, ro);
                if (ro) hdr_oe = 1;
            end
        end
        check(!hdr_oe, {"R5 enable low in header ", tag}, int'(hdr_oe), 0);
        if (stop_bit >= 40 && op == 8'h0B) begin
            for (int k = 0; k < nbytes; k++) begin
                exp_q.push_back(int'(model[(int'(addr[AB-1:0]) + k) % NENT]));
                tag_q.push_back($sformatf("R1 R4 R6 byte %0d %s", k, tag));
            end
            for (int k = 0; k < nbytes; k++) begin
                by = '0;
                for (int j = 0; j < 8; j++) begin
                    spi_bit(mode, 1'($urandom_range(1)), rb, ro);
                    by = {by[6:0], rb};
                    if (!ro) data_gap = 1;
                end
                got_q.push_back(int'(by));
            end
            check(!data_gap, {"R6 enable held through stream ", tag}, int'(data_gap), 0);
        end else if (stop_bit >= 40) begin
            for (int k = 0; k < nbytes * 8; k++) begin
                spi_bit(mode, 1'b1, rb, ro);
                if (ro) rej_oe = 1;
            end
            check(!rej_oe, {"R8 unknown opcode stays quiet ", tag}, int'(rej_oe), 0);
        end
        wait_h();
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        check(oe == 1'b0, {"R9 enable drops on deselect ", tag}, int'(oe), 0);
        wait_h(); wait_h(); wait_h(); wait_h();
    endtask

    // Monitor: compare received bytes against expectations in order.
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                int    g, e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(g == e, t, g, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(oe == 1'b0, "R11 enable low in reset", int'(oe), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(oe == 1'b0, "R11 enable low after reset", int'(oe), 0);

        for (int i = 0; i < NENT; i++) begin
            model[i] = 8'((i * 37 + 5) ^ 8'hA0);
            ld_en    = 1'b1;
            ld_addr  = AB'(i);
            ld_data  = model[i];
            @(negedge clk);
        end
        ld_en = 1'b0;
        @(negedge clk);

        // R1 R10: basic read, mode 0
        spi_cmd(0, 8'h0B, 24'h000003, 8'h00, 4, 40, "R1 R10 mode0 addr3");
        // R2 R3 R10: high address bits set, dummy all ones, mode 3
        spi_cmd(3, 8'h0B, 24'hABCDE5, 8'hFF, 5, 40, "R2 R3 R10 mode3 highbits");
        // R3: same address with another dummy value
        spi_cmd(0, 8'h0B, 24'h000005, 8'h5A, 3, 40, "R3 dummy 5A");
        // R7: read across the top entry
        spi_cmd(0, 8'h0B, 24'h00000E, 8'h00, 5, 40, "R7 wrap mode0");
        // R8: unknown opcode
        spi_cmd(0, 8'h03, 24'h000001, 8'h00, 2, 40, "R8 opcode 03");
        // R9: abort in the address field, then a fresh command
        spi_cmd(3, 8'h0B, 24'hFFFFFF, 8'h00, 0, 20, "R9 abort");
        spi_cmd(3, 8'h0B, 24'h000007, 8'h00, 3, 40, "R9 after abort mode3");
        // R6 R7: long stream circling the array, mode 3
        spi_cmd(3, 8'h0B, 24'h00000C, 8'h33, 20, 40, "R6 R7 long stream mode3");

        repeat (20) @(negedge clk);
        check(got_q.size() == 0 && exp_q.size() == 0, "R1 scoreboard drained",
              got_q.size(), exp_q.size());
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule